// File: doc/BRIEF.md
# Memory Protection Rule Table

This block sits in front of a DRAM controller and screens every memory transaction against a table of twenty protection rules. Each transaction presents address bits [31:20] (its 1 MiB page), a 12-bit transaction ID, a port number and a secure/non-secure attribute. One clock edge later the block answers with accept or reject. A rule covers an inclusive page window, an inclusive ID range, a set of ports and the security attributes it applies to. When no valid rule covers a transaction, a per-port default bit decides.

Software never addresses a rule directly. It fills three staging registers (page window, ID range, rule attributes) and then writes a rule number into the control register with a commit bit. To read a rule back, it writes the rule number with a fetch bit and then reads the staging registers. A small access state machine sequences this. It has three states: `ST_IDLE`, `ST_COMMIT` and `ST_FETCH`.
- A control write with bit 5 set takes `ST_IDLE` to `ST_COMMIT`.
- A control write with bit 6 set (and bit 5 clear) takes `ST_IDLE` to `ST_FETCH`.
- `ST_COMMIT` and `ST_FETCH` each return to `ST_IDLE` after one cycle.
- Any other cycle stays in `ST_IDLE`.

Top module: `prot_rule_table`

## Requirements
- R1: After reset every rule is invalid, the default register is 0, all staging registers read 0 and `resp_valid` is low, so any request on ports 0 to 9 is accepted.
- R2: Register offset 0 is the control register. Bits [4:0] select a rule. Writing bit 5 with a rule number copies the three staging registers into that rule, and the copy takes effect for requests from the second rising edge after the write.
- R3: Writing bit 6 (with bit 5 clear) and a rule number loads that rule into the staging registers by the second rising edge after the write. The staging registers read back as follows. Offset 1 holds the start page in [11:0] and the end page in [23:12]. Offset 2 holds the low ID in [11:0] and the high ID in [23:12]. Offset 3 holds the security bits in [1:0], valid in [2], the port mask in [12:3] and the result in [13].
- R4: A valid rule covers a request only when `req_page` lies between its start and end pages, both inclusive.
- R5: A valid rule covers a request only when `req_id` lies between its low and high IDs, both inclusive.
- R6: A valid rule covers a request only when the port mask bit for `req_port` is set and the security bits enable the request's attribute: bit 0 for secure, bit 1 for non-secure.
- R7: A covering rule with result 0 accepts the request, and one with result 1 rejects it.
- R8: When several rules cover a request, the lowest-numbered rule decides.
- R9: When no rule covers a request, bit p of the default register (offset 4, bits [9:0]) decides for port p, where 1 means reject. A port number of 10 or more is always rejected.
- R10: `resp_valid` rises exactly one rising edge after each cycle with `req_valid` high and is low otherwise. Back-to-back requests get back-to-back responses.
- R11: A commit to a rule number of 20 or more changes no rule. A fetch of such a number loads zeros.
- R12: The control register reads back the selected rule number in [4:0], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 control, 1 page window, 2 ID range, 3 attributes, 4 default) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data for `reg_addr`, combinational |
| req_valid | input | 1 | Transaction present |
| req_page | input | 12 | Transaction address bits [31:20] |
| req_id | input | 12 | Transaction ID |
| req_port | input | 4 | Originating port |
| req_secure | input | 1 | 1 for a secure transaction |
| resp_valid | output | 1 | Verdict present |
| resp_accept | output | 1 | 1 accept, 0 reject |

## Verification
A verdict is due one rising edge after its request. The driver pushes the expected verdict into a queue when it raises `req_valid` at a falling edge. The monitor pops and compares that verdict at the next falling edge, when `resp_valid` must be high. A commit or fetch completes on the second rising edge after the control write, so the register tasks idle one extra cycle before any request or read-back relies on it. Register reads are combinational and are sampled just after the offset is driven.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int NUM_RULES = 20;
    localparam int NUM_PORTS = 10;
    localparam int PAGE_W    = 12;
    localparam int ID_W      = 12;
    localparam int REG_W     = 2 * PAGE_W;
    localparam int SEL_W     = $clog2(NUM_RULES);
    localparam int PORT_W    = $clog2(NUM_PORTS);
    localparam int OFF_W     = 3;
    localparam int COMMIT_BIT = 5;
    localparam int FETCH_BIT  = 6;

    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [OFF_W-1:0] OFF_WIN  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_IDR  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_ATTR = 3'd3;
    localparam logic [OFF_W-1:0] OFF_DFLT = 3'd4;

    typedef struct packed {
        logic [PAGE_W-1:0]    pg_hi;
        logic [PAGE_W-1:0]    pg_lo;
        logic [ID_W-1:0]      id_hi;
        logic [ID_W-1:0]      id_lo;
        logic                 rsl;
        logic [NUM_PORTS-1:0] pmask;
        logic                 vld;
        logic [1:0]           sec;
    } rule_t;

    typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_FETCH} acc_state_e;
endpackage

// File: rtl/prt_regif.sv
module prt_regif
    import prt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [OFF_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 rule_we,
    output logic [SEL_W-1:0]     rule_idx,
    output rule_t                stage,
    input  rule_t                fetched,
    output logic [NUM_PORTS-1:0] dflt
);
    acc_state_e state, state_nx;
    logic [SEL_W-1:0] sel;
    logic ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_wr && reg_wdata[COMMIT_BIT])     state_nx = ST_COMMIT;
                else if (ctrl_wr && reg_wdata[FETCH_BIT]) state_nx = ST_FETCH;
                else                                      state_nx = ST_IDLE;
            end
            ST_COMMIT: state_nx = ST_IDLE;
            ST_FETCH:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rule_we  = (state == ST_COMMIT);
        rule_idx = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel   <= '0;
            stage <= '0;
            dflt  <= '0;
        end else if (state == ST_FETCH) begin
            stage <= fetched;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFF_CTRL: sel <= reg_wdata[SEL_W-1:0];
                OFF_WIN: begin
                    stage.pg_lo <= reg_wdata[PAGE_W-1:0];
                    stage.pg_hi <= reg_wdata[2*PAGE_W-1:PAGE_W];
                end
                OFF_IDR: begin
                    stage.id_lo <= reg_wdata[ID_W-1:0];
                    stage.id_hi <= reg_wdata[2*ID_W-1:ID_W];
                end
                OFF_ATTR: begin
                    stage.sec   <= reg_wdata[1:0];
                    stage.vld   <= reg_wdata[2];
                    stage.pmask <= reg_wdata[NUM_PORTS+2:3];
                    stage.rsl   <= reg_wdata[NUM_PORTS+3];
                end
                OFF_DFLT: dflt <= reg_wdata[NUM_PORTS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CTRL: reg_rdata[SEL_W-1:0] = sel;
            OFF_WIN:  reg_rdata = {stage.pg_hi, stage.pg_lo};
            OFF_IDR:  reg_rdata = {stage.id_hi, stage.id_lo};
            OFF_ATTR: reg_rdata[NUM_PORTS+3:0] = {stage.rsl, stage.pmask, stage.vld, stage.sec};
            OFF_DFLT: reg_rdata[NUM_PORTS-1:0] = dflt;
            default:  reg_rdata = '0;
        endcase
    end

    assert_commit_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ctrl_wr && reg_wdata[COMMIT_BIT]) |=> rule_we);
    assert_commit_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state == ST_IDLE));
    assert_fetch_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_IDLE && stage == $past(fetched)));
endmodule

// File: rtl/prt_rule_store.sv
module prt_rule_store
    import prt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     idx,
    input  rule_t                wrule,
    output rule_t                rrule,
    input  logic [PAGE_W-1:0]    page,
    input  logic [ID_W-1:0]      id,
    input  logic [NUM_PORTS-1:0] port_oh,
    input  logic                 secure,
    output logic [NUM_RULES-1:0] hit,
    output logic [NUM_RULES-1:0] rsl_vec
);
    rule_t rules [NUM_RULES];
    logic [NUM_RULES-1:0] vld_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RULES; i++) rules[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_RULES; i++)
                if (idx == SEL_W'(i)) rules[i] <= wrule;
        end
    end

    always_comb begin
        rrule = '0;
        for (int i = 0; i < NUM_RULES; i++)
            if (idx == SEL_W'(i)) rrule = rules[i];
    end

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
        logic in_win, in_ids, port_ok, sec_ok;
        assign in_win  = (page >= rules[g].pg_lo) && (page <= rules[g].pg_hi);
        assign in_ids  = (id >= rules[g].id_lo) && (id <= rules[g].id_hi);
        assign port_ok = |(rules[g].pmask & port_oh);
        assign sec_ok  = secure ? rules[g].sec[0] : rules[g].sec[1];
        assign hit[g]     = rules[g].vld && in_win && in_ids && port_ok && sec_ok;
        assign rsl_vec[g] = rules[g].rsl;
        assign vld_vec[g] = rules[g].vld;
    end

    assert_idle_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(vld_vec));
    assert_range_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx >= SEL_W'(NUM_RULES)) |=> $stable(vld_vec));
endmodule

// File: rtl/prt_decide.sv
module prt_decide
    import prt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [NUM_RULES-1:0] hit,
    input  logic [NUM_RULES-1:0] rsl_vec,
    input  logic [NUM_PORTS-1:0] dflt,
    input  logic [NUM_PORTS-1:0] port_oh,
    output logic                 resp_valid,
    output logic                 resp_accept
);
    logic [NUM_RULES-1:0] win;
    logic reject;

    always_comb begin
        win = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--)
            if (hit[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        if (|hit)          reject = |(win & rsl_vec);
        else if (|port_oh) reject = |(dflt & port_oh);
        else               reject = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            resp_accept <= req_valid && !reject;
        end
    end

    assert_resp_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win) && ((|win) == (|hit)));
    assert_quiet_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_accept);
endmodule

// File: rtl/prot_rule_table.sv
module prot_rule_table
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [ID_W-1:0]   req_id,
    input  logic [PORT_W-1:0] req_port,
    input  logic              req_secure,
    output logic              resp_valid,
    output logic              resp_accept
);
    rule_t stage, fetched;
    logic rule_we;
    logic [SEL_W-1:0] rule_idx;
    logic [NUM_PORTS-1:0] dflt, port_oh;
    logic [NUM_RULES-1:0] hit, rsl_vec;

    assign port_oh = NUM_PORTS'(1) << req_port;

    prt_regif u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rule_we(rule_we),
        .rule_idx(rule_idx), .stage(stage), .fetched(fetched), .dflt(dflt)
    );

    prt_rule_store u_store (
        .clk(clk), .rst_n(rst_n), .we(rule_we), .idx(rule_idx), .wrule(stage),
        .rrule(fetched), .page(req_page), .id(req_id), .port_oh(port_oh),
        .secure(req_secure), .hit(hit), .rsl_vec(rsl_vec)
    );

    prt_decide u_decide (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
        .rsl_vec(rsl_vec), .dflt(dflt), .port_oh(port_oh),
        .resp_valid(resp_valid), .resp_accept(resp_accept)
    );
endmodule

// File: tb/tb_prot_rule_table.sv
module tb_prot_rule_table;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [23:0] reg_wdata = '0, reg_rdata;
    logic req_valid = 1'b0, req_secure = 1'b0;
    logic [11:0] req_page = '0, req_id = '0;
    logic [3:0] req_port = '0;
    logic resp_valid, resp_accept;

    int errors = 0, checks = 0;
    bit exp_q[$];
    string tag_q[$];

    int m_lo[20], m_hi[20], m_il[20], m_ih[20], m_pm[20], m_sec[20];
    bit m_vld[20], m_rsl[20];
    int m_dflt = 0;

    always #4 clk = ~clk;

    prot_rule_table dut (.*);

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_accept(int page, int id, int port, bit s);
        for (int i = 0; i < 20; i++)
            if (m_vld[i] && page >= m_lo[i] && page <= m_hi[i] && id >= m_il[i] &&
                id <= m_ih[i] && port < 10 && m_pm[i][port] &&
                (s ? m_sec[i][0] : m_sec[i][1]))
                return !m_rsl[i];
        if (port >= 10) return 1'b0;
        return !m_dflt[port];
    endfunction

    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) check("R10 unexpected response", 1, 0);
            else check(tag_q.pop_front(), resp_accept, exp_q.pop_front());
        end
    end

    task automatic wr(input int off, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off[2:0]; reg_wdata = d[23:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int off, input int exp, input string req);
        @(negedge clk);
        reg_addr = off[2:0];
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic set_rule(input int n, input int lo, input int hi, input int il,
                            input int ih, input int sec, input bit vld,
                            input int pm, input bit rsl);
        wr(1, (hi << 12) | lo);
        wr(2, (ih << 12) | il);
        wr(3, (int'(rsl) << 13) | (pm << 3) | (int'(vld) << 2) | sec);
        wr(0, n | 32'h20);
        @(negedge clk);
        if (n < 20) begin
            m_lo[n] = lo; m_hi[n] = hi; m_il[n] = il; m_ih[n] = ih;
            m_sec[n] = sec; m_vld[n] = vld; m_pm[n] = pm; m_rsl[n] = rsl;
        end
    endtask

    task automatic send(input int page, input int id, input int port, input bit s,
                        input string req);
        @(negedge clk);
        req_valid = 1'b1; req_page = page[11:0]; req_id = id[11:0];
        req_port = port[3:0]; req_secure = s;
        exp_q.push_back(exp_accept(page, id, port, s));
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20; i++) begin
            m_vld[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_il[i] = 0; m_ih[i] = 0;
            m_pm[i] = 0; m_sec[i] = 0; m_rsl[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 resp_valid at reset", resp_valid, 0);
        rst_n = 1'b1;
        rd(1, 0, "R1 window staging zero");
        rd(3, 0, "R1 attribute staging zero");
        rd(4, 0, "R1 default zero");
        send(12'h345, 7, 4, 1, "R1 empty table accepts");
        idle();

        // rule 3: pages 0x100..0x1FF, ids 0x10..0x20, port 2 only, both attrs, reject
        set_rule(3, 12'h100, 12'h1FF, 12'h010, 12'h020, 3, 1, 10'h004, 1);
        send(12'h150, 12'h015, 2, 0, "R7 covering reject rule");
        send(12'h1FF, 12'h020, 2, 1, "R4 R5 inclusive upper bounds");
        send(12'h100, 12'h010, 2, 0, "R4 R5 inclusive lower bounds");
        send(12'h200, 12'h015, 2, 0, "R4 page above window");
        send(12'h0FF, 12'h015, 2, 0, "R4 page below window");
        send(12'h150, 12'h021, 2, 0, "R5 id above range");
        send(12'h150, 12'h015, 3, 0, "R6 port outside mask");
        idle();

        // rule 1: page 0x180 only, any id, all ports, secure only, accept
        set_rule(1, 12'h180, 12'h180, 12'h000, 12'hFFF, 1, 1, 10'h3FF, 0);
        send(12'h180, 12'h015, 2, 1, "R8 lower rule wins");
        send(12'h180, 12'h015, 2, 0, "R6 R8 non-secure skips rule 1");
        idle();

        // read back rule 3
        wr(0, 3 | 32'h40);
        @(negedge clk);
        rd(1, 32'h1FF100, "R3 fetched window");
        rd(2, 32'h020010, "R3 fetched id range");
        rd(3, (1 << 13) | (4 << 3) | (1 << 2) | 3, "R3 fetched attributes");
        rd(0, 3, "R12 control readback");

        // defaults
        wr(4, 32'h3FF); m_dflt = 32'h3FF;
        send(12'h700, 12'h001, 5, 0, "R9 default reject");
        idle();
        wr(4, 32'h001); m_dflt = 32'h001;
        send(12'h700, 12'h001, 0, 0, "R9 port 0 default reject");
        send(12'h700, 12'h001, 1, 0, "R9 port 1 default accept");
        send(12'h700, 12'h001, 12, 0, "R9 port out of range rejected");
        idle();

        // out-of-range commit and fetch
        set_rule(25, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 3, 1, 10'h3FF, 1);
        send(12'h900, 12'h001, 1, 0, "R11 commit to rule 25 ignored");
        idle();
        wr(0, 25 | 32'h40);
        @(negedge clk);
        rd(1, 0, "R11 fetch of rule 25 gives zero");

        // invalidate rule 3
        set_rule(3, 12'h100, 12'h1FF, 12'h010, 12'h020, 3, 0, 10'h004, 1);
        send(12'h150, 12'h015, 2, 0, "R2 commit cleared rule 3");
        idle();

        repeat (4) @(negedge clk);
        check("R10 all responses returned", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule